// File: doc/BRIEF.md
# Ticket fare transaction controller

This block runs one ticket sale at a time for a bus fare machine. The rider picks one of two routes, one of three per-ticket price tiers (3, 5 or 10 units) and a quantity from 1 to 7, then presses confirm. The controller latches the selection, works out the fare as unit price times quantity, and starts counting inserted notes. Only 5-unit and 10-unit notes are accepted. Each one arrives as a single-cycle strobe on its own input.

When the paid total reaches or passes the fare, the controller issues the ticket with a one-cycle pulse and reports the overpayment as change. It also lights one of six indicators, one for each route and tier pair. A cancel during payment refunds everything paid so far as change and issues nothing. Display driving, note validation and printing are handled by neighbouring blocks.

Top module: `fare_txn_ctrl`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it is released, the controller is idle and paid_total, fare, change, ticket_pulse and combo_led are all zero. One cycle after idle the controller waits for a selection.
- R2: A confirm with a valid selection latches the fare. The fare appears on the output one cycle later. Tier code 0 costs 3 units per ticket, code 1 costs 5 and code 2 costs 10, and the fare is the unit price times qty_sel. The same edge clears paid_total and change.
- R3: A confirm is refused if qty_sel is 0, tier_sel is 3 or route_sel is 2 or above. In that case the controller keeps waiting for a selection and fare stays unchanged.
- R4: While payment is open and the total is still below the fare, coin_lo adds 5 and coin_hi adds 10 to paid_total on the next edge. Both in one cycle add 15. Strobes are ignored outside payment, in the cycle the total already covers the fare, and in a cancel cycle.
- R5: During payment, route_sel, tier_sel, qty_sel and confirm have no effect. The fare stays as latched.
- R6: Once paid_total is at least the fare, ticket_pulse is high for exactly one cycle on the next edge. In that same cycle change equals paid_total minus fare, which is zero for exact payment.
- R7: When the ticket is issued, combo_led has exactly one bit set, at index route*3 + tier of the latched selection. It stays lit until the next accepted confirm. At most one bit is ever set.
- R8: A cancel during payment sets change to the paid total on the next edge, with no ticket pulse and no indicator. The controller then returns to idle. A cancel outside payment has no effect.
- R9: paid_total is 7 bits wide with the default parameters. It never overflows: the largest fare plus the largest single-cycle insertion stays within range.
- R10: change and fare hold their values until the next accepted confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| route_sel | input | 2 | Route code, 0 or 1 valid |
| tier_sel | input | 2 | Price tier code, 0..2 valid |
| qty_sel | input | 3 | Ticket quantity, 1..7 valid |
| coin_lo | input | 1 | Strobe: a 5-unit note was inserted |
| coin_hi | input | 1 | Strobe: a 10-unit note was inserted |
| confirm | input | 1 | Strobe: accept the present selection |
| cancel | input | 1 | Strobe: abandon payment and refund |
| paid_total | output | 7 | Amount inserted in this transaction |
| fare | output | 7 | Latched fare |
| change | output | 7 | Change or refund owed |
| ticket_pulse | output | 1 | One-cycle ticket issue pulse |
| combo_led | output | 6 | One-hot route/tier indicator |

## Verification
Sales are run with each kind of payment:
- exact payment with a single note;
- exact payment with many notes;
- overpayment with a single note;
- both strobes in the same cycle;
- a note presented in the cycle the total first covers the fare.

Together these separate an off-by-one in the coverage compare, a wrong note weight and an early or late issue cycle. The extremes are the cheapest ticket against a 5-unit note and the dearest fare (70) overshot to 80. They check the multiplier and the total's width.

Several sequences check that input is ignored when it should be:
- each of the three invalid selection codes;
- selection changes and confirms during payment;
- a cancel outside payment.

A cancel in the middle of payment checks that the refund differs from the normal change.

// File: rtl/fare_pkg.sv
`timescale 1ns/1ps
package fare_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SELECT = 2'd1,
      ST_PAY    = 2'd2,
      ST_ISSUE  = 2'd3
   } txn_state_t;

   localparam int NUM_TIERS = 3;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/fare_sel_check.sv
`timescale 1ns/1ps
module fare_sel_check
   import fare_pkg::*;
#(
   parameter int ROUTE_W    = 2,
   parameter int TIER_W     = 2,
   parameter int QTY_W      = 3,
   parameter int AMT_W      = 7,
   parameter int IDX_W      = 3,
   parameter int NUM_ROUTES = 2,
   parameter int PRICE_LO   = 3,
   parameter int PRICE_MID  = 5,
   parameter int PRICE_HI   = 10,
   parameter bit SHIFT_ADD  = 1'b0
) (
   input  logic [ROUTE_W-1:0] route,
   input  logic [TIER_W-1:0]  tier,
   input  logic [QTY_W-1:0]   qty,
   output logic               sel_ok,
   output logic [AMT_W-1:0]   fare_calc,
   output logic [IDX_W-1:0]   combo_idx
);

   logic [AMT_W-1:0] unit_price;
   logic             tier_ok;
   logic             route_ok;

   always_comb begin
      unit_price = '0;
      tier_ok    = 1'b1;
      case (int'(tier))
         0:       unit_price = AMT_W'(PRICE_LO);
         1:       unit_price = AMT_W'(PRICE_MID);
         2:       unit_price = AMT_W'(PRICE_HI);
         default: tier_ok    = 1'b0;
      endcase
   end

   assign route_ok  = int'(route) < NUM_ROUTES;
   assign sel_ok    = tier_ok && route_ok && (qty != '0);
   assign combo_idx = IDX_W'(int'(route) * NUM_TIERS + int'(tier));

   generate
      if (SHIFT_ADD) begin : g_shift_add
         always_comb begin
            fare_calc = '0;
            for (int b = 0; b < QTY_W; b++) begin
               if (qty[b]) fare_calc = fare_calc + (unit_price << b);
            end
         end
      end else begin : g_multiply
         assign fare_calc = unit_price * AMT_W'(qty);
      end
   endgenerate

endmodule

// File: rtl/fare_accum.sv
`timescale 1ns/1ps
module fare_accum #(
   parameter int AMT_W   = 7,
   parameter int COIN_LO = 5,
   parameter int COIN_HI = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             add_en,
   input  logic             coin_lo,
   input  logic             coin_hi,
   output logic [AMT_W-1:0] paid
);

   logic [AMT_W-1:0] step;

   always_comb begin
      step = '0;
      if (coin_lo) step = step + AMT_W'(COIN_LO);
      if (coin_hi) step = step + AMT_W'(COIN_HI);
   end

   always_ff @(posedge clk) begin
      if (rst || clr)  paid <= '0;
      else if (add_en) paid <= paid + step;
   end

endmodule

// File: rtl/fare_fsm.sv
`timescale 1ns/1ps
module fare_fsm
   import fare_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       sel_ok,
   input  logic       confirm,
   input  logic       cancel,
   input  logic       covered,
   output txn_state_t state,
   output logic       accept,
   output logic       abort,
   output logic       done,
   output logic       add_en
);

   txn_state_t state_d;

   always_comb begin
      accept = (state == ST_SELECT) && confirm && sel_ok;
      abort  = (state == ST_PAY) && cancel;
      done   = (state == ST_PAY) && !cancel && covered;
      add_en = (state == ST_PAY) && !cancel && !covered;
   end

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE:   state_d = ST_SELECT;
         ST_SELECT: if (accept) state_d = ST_PAY;
         ST_PAY: begin
            if (abort)     state_d = ST_IDLE;
            else if (done) state_d = ST_ISSUE;
         end
         ST_ISSUE:  state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_d;
   end

endmodule

// File: rtl/fare_txn_ctrl.sv
`timescale 1ns/1ps
module fare_txn_ctrl
   import fare_pkg::*;
#(
   parameter int ROUTE_W    = 2,
   parameter int TIER_W     = 2,
   parameter int QTY_W      = 3,
   parameter int NUM_ROUTES = 2,
   parameter int PRICE_LO   = 3,
   parameter int PRICE_MID  = 5,
   parameter int PRICE_HI   = 10,
   parameter int COIN_LO    = 5,
   parameter int COIN_HI    = 10,
   parameter bit SHIFT_ADD  = 1'b0,
   localparam int MAX_QTY   = (1 << QTY_W) - 1,
   localparam int MAX_FARE  = max3(PRICE_LO, PRICE_MID, PRICE_HI) * MAX_QTY,
   localparam int MAX_PAID  = MAX_FARE - 1 + COIN_LO + COIN_HI,
   localparam int AMT_W     = $clog2(MAX_PAID + 1),
   localparam int NUM_COMBO = NUM_ROUTES * NUM_TIERS,
   localparam int IDX_W     = (NUM_COMBO > 1) ? $clog2(NUM_COMBO) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ROUTE_W-1:0]   route_sel,
   input  logic [TIER_W-1:0]    tier_sel,
   input  logic [QTY_W-1:0]     qty_sel,
   input  logic                 coin_lo,
   input  logic                 coin_hi,
   input  logic                 confirm,
   input  logic                 cancel,
   output logic [AMT_W-1:0]     paid_total,
   output logic [AMT_W-1:0]     fare,
   output logic [AMT_W-1:0]     change,
   output logic                 ticket_pulse,
   output logic [NUM_COMBO-1:0] combo_led
);

   generate
      if (PRICE_LO < 1 || PRICE_MID < 1 || PRICE_HI < 1) begin : g_bad_price
         $error("every price tier must be at least one unit");
      end
      if (COIN_LO < 1 || COIN_HI < 1) begin : g_bad_coin
         $error("note values must be positive");
      end
      if (TIER_W < 2) begin : g_bad_tier_w
         $error("tier code needs two bits for three tiers");
      end
      if (NUM_ROUTES < 1 || NUM_ROUTES > (1 << ROUTE_W)) begin : g_bad_routes
         $error("route count does not fit the route code");
      end
      if (QTY_W < 1) begin : g_bad_qty_w
         $error("quantity code needs at least one bit");
      end
   endgenerate

   txn_state_t           state_q;
   logic                 sel_ok;
   logic [AMT_W-1:0]     fare_calc;
   logic [IDX_W-1:0]     combo_idx;
   logic [IDX_W-1:0]     idx_q;
   logic [AMT_W-1:0]     fare_q;
   logic [AMT_W-1:0]     change_q;
   logic [NUM_COMBO-1:0] led_q;
   logic [NUM_COMBO-1:0] led_hit;
   logic                 accept, abort, done, add_en, covered;

   fare_sel_check #(
      .ROUTE_W   (ROUTE_W),
      .TIER_W    (TIER_W),
      .QTY_W     (QTY_W),
      .AMT_W     (AMT_W),
      .IDX_W     (IDX_W),
      .NUM_ROUTES(NUM_ROUTES),
      .PRICE_LO  (PRICE_LO),
      .PRICE_MID (PRICE_MID),
      .PRICE_HI  (PRICE_HI),
      .SHIFT_ADD (SHIFT_ADD)
   ) u_sel (
      .route    (route_sel),
      .tier     (tier_sel),
      .qty      (qty_sel),
      .sel_ok   (sel_ok),
      .fare_calc(fare_calc),
      .combo_idx(combo_idx)
   );

   fare_fsm u_fsm (
      .clk    (clk),
      .rst    (rst),
      .sel_ok (sel_ok),
      .confirm(confirm),
      .cancel (cancel),
      .covered(covered),
      .state  (state_q),
      .accept (accept),
      .abort  (abort),
      .done   (done),
      .add_en (add_en)
   );

   fare_accum #(
      .AMT_W  (AMT_W),
      .COIN_LO(COIN_LO),
      .COIN_HI(COIN_HI)
   ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clr    (accept),
      .add_en (add_en),
      .coin_lo(coin_lo),
      .coin_hi(coin_hi),
      .paid   (paid_total)
   );

   assign covered = paid_total >= fare_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         fare_q   <= '0;
         change_q <= '0;
         idx_q    <= '0;
      end else if (accept) begin
         fare_q   <= fare_calc;
         change_q <= '0;
         idx_q    <= combo_idx;
      end else if (abort) begin
         change_q <= paid_total;
      end else if (done) begin
         change_q <= paid_total - fare_q;
      end
   end

   for (genvar i = 0; i < NUM_COMBO; i++) begin : g_led
      assign led_hit[i] = done && (idx_q == IDX_W'(i));
   end

   always_ff @(posedge clk) begin
      if (rst || accept) led_q <= '0;
      else               led_q <= led_q | led_hit;
   end

   assign fare         = fare_q;
   assign change       = change_q;
   assign combo_led    = led_q;
   assign ticket_pulse = (state_q == ST_ISSUE);

endmodule

// File: rtl/fare_txn_chk.sv
`timescale 1ns/1ps
module fare_txn_chk
   import fare_pkg::*;
#(
   parameter int AMT_W     = 7,
   parameter int NUM_COMBO = 6,
   parameter int MAX_PAID  = 84
) (
   input logic                 clk,
   input logic                 rst,
   input txn_state_t           state,
   input logic                 cancel,
   input logic [AMT_W-1:0]     paid,
   input logic [AMT_W-1:0]     fare,
   input logic [AMT_W-1:0]     change,
   input logic                 pulse,
   input logic [NUM_COMBO-1:0] led
);

   // R7
   led_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(led));

   // R7
   issue_led_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |-> ($countones(led) == 1));

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |=> !pulse);

   // R6
   issue_change_chk: assert property (@(posedge clk) disable iff (rst)
      pulse |-> (change == AMT_W'(paid - fare)));

   // R6
   covered_issue_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PAY && !cancel && paid >= fare) |=> (state == ST_ISSUE));

   // R8
   cancel_refund_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PAY && cancel) |=>
         (state == ST_IDLE && change == $past(paid) && led == '0 && !pulse));

   // R5
   fare_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PAY) |=> $stable(fare));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      paid <= AMT_W'(MAX_PAID));

endmodule

bind fare_txn_ctrl fare_txn_chk #(
   .AMT_W    (AMT_W),
   .NUM_COMBO(NUM_COMBO),
   .MAX_PAID (MAX_PAID)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .state (state_q),
   .cancel(cancel),
   .paid  (paid_total),
   .fare  (fare),
   .change(change),
   .pulse (ticket_pulse),
   .led   (combo_led)
);

// File: tb/sim_fare_txn_ctrl.sv
`timescale 1ns/1ps
module sim_fare_txn_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] route_sel = '0;
   logic [1:0] tier_sel = '0;
   logic [2:0] qty_sel = '0;
   logic       coin_lo = 1'b0;
   logic       coin_hi = 1'b0;
   logic       confirm = 1'b0;
   logic       cancel = 1'b0;
   logic [6:0] paid_total, fare, change;
   logic       ticket_pulse;
   logic [5:0] combo_led;

   int vectors = 0;
   int miscompares = 0;

   always #5 clk = ~clk;

   fare_txn_ctrl u0 (
      .clk         (clk),
      .rst         (rst),
      .route_sel   (route_sel),
      .tier_sel    (tier_sel),
      .qty_sel     (qty_sel),
      .coin_lo     (coin_lo),
      .coin_hi     (coin_hi),
      .confirm     (confirm),
      .cancel      (cancel),
      .paid_total  (paid_total),
      .fare        (fare),
      .change      (change),
      .ticket_pulse(ticket_pulse),
      .combo_led   (combo_led)
   );

   // behavioural reference: 0 idle, 1 select, 2 pay, 3 issue
   int m_st = 0, m_paid = 0, m_fare = 0, m_chg = 0, m_led = 0, m_idx = 0;
   bit m_on = 0;

   function automatic int unit_price(input int t);
      if (t == 0) return 3;
      if (t == 1) return 5;
      return 10;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_paid = 0; m_fare = 0; m_chg = 0; m_led = 0; m_idx = 0;
         m_on = 1;
      end else begin
         case (m_st)
            0: m_st = 1;
            1: if (confirm && qty_sel != 0 && tier_sel < 3 && route_sel < 2) begin
                  m_fare = unit_price(int'(tier_sel)) * int'(qty_sel);
                  m_paid = 0; m_chg = 0; m_led = 0;
                  m_idx  = int'(route_sel) * 3 + int'(tier_sel);
                  m_st   = 2;
               end
            2: if (cancel) begin
                  m_chg = m_paid; m_st = 0;
               end else if (m_paid >= m_fare) begin
                  m_chg = m_paid - m_fare; m_led = 1 << m_idx; m_st = 3;
               end else begin
                  m_paid = m_paid + (coin_lo ? 5 : 0) + (coin_hi ? 10 : 0);
               end
            default: m_st = 0;
         endcase
      end
   end

   task automatic cmp(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      if (m_on) begin
         cmp("R4 paid_total", int'(paid_total), m_paid);
         cmp("R2 fare", int'(fare), m_fare);
         cmp("R6 change", int'(change), m_chg);
         cmp("R6 ticket_pulse", int'(ticket_pulse), (m_st == 3) ? 1 : 0);
         cmp("R7 combo_led", int'(combo_led), m_led);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic pick(input int r, input int t, input int q);
      route_sel = 2'(r); tier_sel = 2'(t); qty_sel = 3'(q);
      confirm = 1'b1;
      cyc();
      confirm = 1'b0;
   endtask

   task automatic note(input bit lo, input bit hi);
      coin_lo = lo; coin_hi = hi;
      cyc();
      coin_lo = 1'b0; coin_hi = 1'b0;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      wait_n(3);
      cmp("R1 paid_total", int'(paid_total), 0);
      cmp("R1 combo_led", int'(combo_led), 0);
      cmp("R1 ticket_pulse", int'(ticket_pulse), 0);
      rst = 1'b0;
      wait_n(2);

      // R3 invalid selections refused; R4 notes ignored in select; R8 cancel ignored
      pick(0, 0, 0);
      pick(0, 3, 2);
      pick(2, 1, 2);
      pick(3, 0, 1);
      note(1'b1, 1'b0);
      cancel = 1'b1; cyc(); cancel = 1'b0;
      cmp("R3 fare after refused confirm", int'(fare), 0);
      cmp("R3 paid ignored before acceptance", int'(paid_total), 0);

      // R2 cheapest ticket overpaid with a 5 note: change 2, index 0
      pick(0, 0, 1);
      note(1'b1, 1'b0);
      wait_n(4);
      cmp("R6 change overpay", int'(change), 2);
      cmp("R7 led index 0", int'(combo_led), 1);

      // R5 dearest fare, exact with seven 10 notes, selection wiggled meanwhile
      pick(1, 2, 7);
      route_sel = 2'd0; tier_sel = 2'd0; qty_sel = 3'd1;
      confirm = 1'b1; note(1'b0, 1'b1); confirm = 1'b0;
      for (int k = 0; k < 6; k++) note(1'b0, 1'b1);
      wait_n(4);
      cmp("R5 fare unchanged by selection during pay", int'(fare), 70);
      cmp("R6 change exact", int'(change), 0);
      cmp("R7 led index 5", int'(combo_led), 32);

      // R10 values held across idle cycles
      wait_n(5);
      cmp("R10 change held", int'(change), 0);
      cmp("R10 fare held", int'(fare), 70);

      // R4 both strobes at once: fare 15
      pick(1, 1, 3);
      note(1'b1, 1'b1);
      wait_n(4);
      cmp("R4 combined strobe", int'(paid_total), 15);
      cmp("R7 led index 4", int'(combo_led), 16);

      // R4 note during the covering cycle is refused: fare 5
      pick(0, 1, 1);
      note(1'b0, 1'b1);
      note(1'b1, 1'b0);
      wait_n(4);
      cmp("R4 refused note after cover", int'(paid_total), 10);
      cmp("R6 change after cover", int'(change), 5);

      // R8 cancel during pay: fare 20, refund 5
      pick(0, 2, 2);
      note(1'b1, 1'b0);
      cancel = 1'b1; cyc(); cancel = 1'b0;
      wait_n(3);
      cmp("R8 refund", int'(change), 5);
      cmp("R8 no indicator", int'(combo_led), 0);

      // R9 largest total: fare 70 reached via 65 then 15 -> 80
      pick(1, 2, 7);
      for (int k = 0; k < 6; k++) note(1'b0, 1'b1);
      note(1'b1, 1'b0);
      note(1'b1, 1'b1);
      wait_n(4);
      cmp("R9 no overflow", int'(paid_total), 80);
      cmp("R9 change at maximum", int'(change), 10);

      // R2 route 1 tier 0 qty 5 = 15, paid 20
      pick(1, 0, 5);
      note(1'b0, 1'b1);
      note(1'b0, 1'b1);
      wait_n(4);
      cmp("R2 fare route1 tier0", int'(fare), 15);
      cmp("R7 led index 3", int'(combo_led), 8);

      summary();
      $finish;
   end

endmodule